// File: doc/BRIEF.md
# Constant-Assembling Accumulator

This unit builds wide immediate constants out of a stream of 16-bit immediate fields. It keeps a private 64-bit accumulator. Each load step shifts the accumulator left by one halfword and puts the new immediate in the lowest halfword. Other step kinds clear the accumulator or zero-extend a 16-bit or 32-bit value. When the constant is complete, a commit strobe sends the whole 64-bit word to a destination register index. The register file and the operand crossbar therefore only ever receive full-width words and never have to do a partial write.

The accumulator is part of the context that is saved on an interrupt. A save strobe copies its value out to a context port. A restore strobe loads a full word back into it, so a constant sequence that was cut off by an interrupt can continue where it stopped. The result depends only on the order of the steps, not on how the surrounding pipeline is organised.

Top module: `const_acc`

## Requirements
- R1: While `rst_n` is low at a clock edge, the accumulator becomes zero and `wr_en_o` and `save_vld_o` become 0. A commit issued as the first operation after reset writes 0.
- R2: A step with `ld_i`=1 and `ld_mode_i`=0 (shift) sets the accumulator to {old bits 47:0, `ld_imm_i`}.
- R3: A clear step followed by four shift steps gives an exact 64-bit constant. The first halfword lands in bits 63:48 and the last halfword lands in bits 15:0.
- R4: A step with `ld_mode_i`=1 (zero-extend 16) sets the accumulator to {48 zero bits, `ld_imm_i`}.
- R5: A step with `ld_mode_i`=2 (zero-extend 32) sets the accumulator to {32 zero bits, old bits 15:0, `ld_imm_i`}.
- R6: A step with `ld_mode_i`=3 (clear) sets the accumulator to zero, whatever the value of `ld_imm_i`.
- R7: A commit in cycle N sets `wr_en_o` high for exactly cycle N+1. In that cycle `wr_idx_o` equals the destination index from cycle N and `wr_data_o` carries the full 64-bit accumulator value.
- R8: When a commit and a load step occur in the same cycle, the word that is written already includes that step.
- R9: A save in cycle N sets `save_vld_o` high for cycle N+1. In that cycle `save_data_o` holds the accumulator value from before any step taken in cycle N.
- R10: A restore loads `restore_data_i` into the accumulator. When a load step occurs in the same cycle, the restore wins and the step is dropped.
- R11: When neither `ld_i` nor `restore_i` is high, the accumulator holds its value, and changes on `ld_imm_i` or `ld_mode_i` have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ld_i | input | 1 | Load-step strobe |
| ld_mode_i | input | 2 | Step kind: 0 shift, 1 zero-extend 16, 2 zero-extend 32, 3 clear |
| ld_imm_i | input | 16 | Immediate halfword |
| commit_i | input | 1 | Write the accumulator to a register |
| commit_dst_i | input | 6 | Destination register index |
| save_i | input | 1 | Copy the accumulator out for interrupt context |
| restore_i | input | 1 | Load the accumulator from context |
| restore_data_i | input | 64 | Context value to restore |
| wr_en_o | output | 1 | Register write enable |
| wr_idx_o | output | 6 | Register write index |
| wr_data_o | output | 64 | Full-width write data |
| save_vld_o | output | 1 | Saved value valid |
| save_data_o | output | 64 | Saved accumulator value |

## Verification
Each output of the unit passes through exactly one register. The effect of a step, commit, save or restore applied before clock edge N therefore appears on the ports right after edge N. The bench drives inputs on the falling edge, waits for one rising edge, and samples on the next falling edge, so every port is checked in the cycle in which its value is due. The accumulator is only visible through the commit and save paths. For this reason the bench keeps its own model of the accumulator and compares that model with every commit and save, including cycles in which several strobes coincide.

// File: rtl/cacc_pkg.sv
package cacc_pkg;

   typedef enum logic [1:0] {
      STEP_SHIFT = 2'd0,
      STEP_ZX16  = 2'd1,
      STEP_ZX32  = 2'd2,
      STEP_CLEAR = 2'd3
   } step_e;

   // number of low halfword slots that survive a step of the given kind
   function automatic int unsigned keep_slots(step_e k, int unsigned slots);
      case (k)
         STEP_SHIFT: return slots;
         STEP_ZX16:  return 1;
         STEP_ZX32:  return 2;
         default:    return 0;
      endcase
   endfunction

endpackage

// File: rtl/cacc_step.sv
module cacc_step
   import cacc_pkg::*;
#(
   parameter int unsigned ACC_W = 64,
   parameter int unsigned IMM_W = 16,
   parameter bit          ZX_EN = 1'b1
) (
   input  logic [ACC_W-1:0] acc_i,
   input  logic [IMM_W-1:0] imm_i,
   input  logic [1:0]       mode_i,
   output logic [ACC_W-1:0] nxt_o
);
   localparam int unsigned SLOTS = ACC_W / IMM_W;

   step_e            kind;
   logic [ACC_W-1:0] shifted;
   int unsigned      keep_n;

   always_comb begin
      kind = step_e'(mode_i);
      if (!ZX_EN && (kind == STEP_ZX16 || kind == STEP_ZX32))
         kind = STEP_SHIFT;
      keep_n  = keep_slots(kind, SLOTS);
      shifted = {acc_i[ACC_W-IMM_W-1:0], imm_i};
   end

   generate
      for (genvar s = 0; s < SLOTS; s++) begin : g_slot
         always_comb begin
            if (s < keep_n)
               nxt_o[s*IMM_W +: IMM_W] = shifted[s*IMM_W +: IMM_W];
            else
               nxt_o[s*IMM_W +: IMM_W] = '0;
         end
      end
   endgenerate

endmodule

// File: rtl/cacc_ctx.sv
module cacc_ctx #(
   parameter int unsigned ACC_W = 64
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             ld_i,
   input  logic [ACC_W-1:0] step_i,
   input  logic             restore_i,
   input  logic [ACC_W-1:0] restore_data_i,
   input  logic             save_i,
   output logic [ACC_W-1:0] acc_o,
   output logic [ACC_W-1:0] acc_nxt_o,
   output logic             save_vld_o,
   output logic [ACC_W-1:0] save_data_o
);
   logic [ACC_W-1:0] acc_q;

   always_comb begin
      if (restore_i)
         acc_nxt_o = restore_data_i;
      else if (ld_i)
         acc_nxt_o = step_i;
      else
         acc_nxt_o = acc_q;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         acc_q      <= '0;
         save_vld_o <= 1'b0;
      end else begin
         acc_q      <= acc_nxt_o;
         save_vld_o <= save_i;
      end
   end

   // save sees the pre-step value
   always_ff @(posedge clk) begin
      if (!rst_n)
         save_data_o <= '0;
      else if (save_i)
         save_data_o <= acc_q;
   end

   assign acc_o = acc_q;

endmodule

// File: rtl/cacc_commit.sv
module cacc_commit #(
   parameter int unsigned ACC_W = 64,
   parameter int unsigned IDX_W = 6
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             commit_i,
   input  logic [IDX_W-1:0] dst_i,
   input  logic [ACC_W-1:0] data_i,
   output logic             wr_en_o,
   output logic [IDX_W-1:0] wr_idx_o,
   output logic [ACC_W-1:0] wr_data_o
);
   always_ff @(posedge clk) begin
      if (!rst_n)
         wr_en_o <= 1'b0;
      else
         wr_en_o <= commit_i;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         wr_idx_o  <= '0;
         wr_data_o <= '0;
      end else if (commit_i) begin
         wr_idx_o  <= dst_i;
         wr_data_o <= data_i;
      end
   end

endmodule

// File: rtl/const_acc.sv
module const_acc #(
   parameter int unsigned ACC_W = 64,
   parameter int unsigned IMM_W = 16,
   parameter int unsigned IDX_W = 6,
   parameter bit          ZX_EN = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             ld_i,
   input  logic [1:0]       ld_mode_i,
   input  logic [IMM_W-1:0] ld_imm_i,
   input  logic             commit_i,
   input  logic [IDX_W-1:0] commit_dst_i,
   input  logic             save_i,
   input  logic             restore_i,
   input  logic [ACC_W-1:0] restore_data_i,
   output logic             wr_en_o,
   output logic [IDX_W-1:0] wr_idx_o,
   output logic [ACC_W-1:0] wr_data_o,
   output logic             save_vld_o,
   output logic [ACC_W-1:0] save_data_o
);
   localparam int unsigned SLOTS = ACC_W / IMM_W;

   generate
      if (ACC_W % IMM_W != 0) begin : g_bad_ratio
         $error("ACC_W must be a multiple of IMM_W");
      end
      if (SLOTS < 2) begin : g_bad_slots
         $error("accumulator needs at least two halfword slots");
      end
      if (IDX_W < 1) begin : g_bad_idx
         $error("IDX_W must be at least 1");
      end
   endgenerate

   logic [ACC_W-1:0] acc_q;
   logic [ACC_W-1:0] acc_nxt;
   logic [ACC_W-1:0] step_val;

   cacc_step #(
      .ACC_W (ACC_W),
      .IMM_W (IMM_W),
      .ZX_EN (ZX_EN)
   ) u_step (
      .acc_i  (acc_q),
      .imm_i  (ld_imm_i),
      .mode_i (ld_mode_i),
      .nxt_o  (step_val)
   );

   cacc_ctx #(
      .ACC_W (ACC_W)
   ) u_ctx (
      .clk            (clk),
      .rst_n          (rst_n),
      .ld_i           (ld_i),
      .step_i         (step_val),
      .restore_i      (restore_i),
      .restore_data_i (restore_data_i),
      .save_i         (save_i),
      .acc_o          (acc_q),
      .acc_nxt_o      (acc_nxt),
      .save_vld_o     (save_vld_o),
      .save_data_o    (save_data_o)
   );

   cacc_commit #(
      .ACC_W (ACC_W),
      .IDX_W (IDX_W)
   ) u_commit (
      .clk       (clk),
      .rst_n     (rst_n),
      .commit_i  (commit_i),
      .dst_i     (commit_dst_i),
      .data_i    (acc_nxt),
      .wr_en_o   (wr_en_o),
      .wr_idx_o  (wr_idx_o),
      .wr_data_o (wr_data_o)
   );

endmodule

// File: rtl/const_acc_chk.sv
module const_acc_chk #(
   parameter int unsigned ACC_W = 64,
   parameter int unsigned IMM_W = 16,
   parameter int unsigned IDX_W = 6
) (
   input logic             clk,
   input logic             rst_n,
   input logic             ld_i,
   input logic [1:0]       ld_mode_i,
   input logic [IMM_W-1:0] ld_imm_i,
   input logic             commit_i,
   input logic [IDX_W-1:0] commit_dst_i,
   input logic             save_i,
   input logic             restore_i,
   input logic [ACC_W-1:0] restore_data_i,
   input logic             wr_en_o,
   input logic [IDX_W-1:0] wr_idx_o,
   input logic [ACC_W-1:0] wr_data_o,
   input logic             save_vld_o,
   input logic [ACC_W-1:0] save_data_o,
   input logic [ACC_W-1:0] acc_q
);
   // R1
   reset_clears_chk: assert property (@(posedge clk)
      !rst_n |=> (!wr_en_o && !save_vld_o && acc_q == '0));

   // R2
   shift_insert_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ld_i && ld_mode_i == 2'd0 && !restore_i) |=>
      acc_q == {$past(acc_q[ACC_W-IMM_W-1:0]), $past(ld_imm_i)});

   // R4
   zx16_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ld_i && ld_mode_i == 2'd1 && !restore_i) |=>
      acc_q[ACC_W-1:IMM_W] == '0);

   // R6
   clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ld_i && ld_mode_i == 2'd3 && !restore_i) |=> acc_q == '0);

   // R7
   commit_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      commit_i |=> (wr_en_o && wr_idx_o == $past(commit_dst_i)));

   // R7
   no_commit_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !commit_i |=> !wr_en_o);

   // R8
   commit_matches_acc_chk: assert property (@(posedge clk) disable iff (!rst_n)
      commit_i |=> wr_data_o == acc_q);

   // R9
   save_old_value_chk: assert property (@(posedge clk) disable iff (!rst_n)
      save_i |=> (save_vld_o && save_data_o == $past(acc_q)));

   // R10
   restore_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
      restore_i |=> acc_q == $past(restore_data_i));

   // R11
   hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!ld_i && !restore_i) |=> $stable(acc_q));

endmodule

bind const_acc const_acc_chk #(
   .ACC_W (ACC_W),
   .IMM_W (IMM_W),
   .IDX_W (IDX_W)
) u_chk (
   .clk            (clk),
   .rst_n          (rst_n),
   .ld_i           (ld_i),
   .ld_mode_i      (ld_mode_i),
   .ld_imm_i       (ld_imm_i),
   .commit_i       (commit_i),
   .commit_dst_i   (commit_dst_i),
   .save_i         (save_i),
   .restore_i      (restore_i),
   .restore_data_i (restore_data_i),
   .wr_en_o        (wr_en_o),
   .wr_idx_o       (wr_idx_o),
   .wr_data_o      (wr_data_o),
   .save_vld_o     (save_vld_o),
   .save_data_o    (save_data_o),
   .acc_q          (acc_q)
);

// File: tb/const_acc_bench.sv
`timescale 1ns/1ps
module const_acc_bench;
   logic        clk = 1'b0;
   logic        rst_n;
   logic        ld_i;
   logic [1:0]  ld_mode_i;
   logic [15:0] ld_imm_i;
   logic        commit_i;
   logic [5:0]  commit_dst_i;
   logic        save_i;
   logic        restore_i;
   logic [63:0] restore_data_i;
   logic        wr_en_o;
   logic [5:0]  wr_idx_o;
   logic [63:0] wr_data_o;
   logic        save_vld_o;
   logic [63:0] save_data_o;

   int checks = 0;
   int errors = 0;
   logic [63:0] exp_acc;
   logic [31:0] seed = 32'h1F2E3D4C;

   always #2 clk = ~clk;

   const_acc u_const_acc (
      .clk(clk), .rst_n(rst_n), .ld_i(ld_i), .ld_mode_i(ld_mode_i),
      .ld_imm_i(ld_imm_i), .commit_i(commit_i), .commit_dst_i(commit_dst_i),
      .save_i(save_i), .restore_i(restore_i), .restore_data_i(restore_data_i),
      .wr_en_o(wr_en_o), .wr_idx_o(wr_idx_o), .wr_data_o(wr_data_o),
      .save_vld_o(save_vld_o), .save_data_o(save_data_o)
   );

   function automatic logic [31:0] rnd(input logic [31:0] s);
      logic [31:0] x = s;
      x = x ^ (x << 13);
      x = x ^ (x >> 17);
      x = x ^ (x << 5);
      return x;
   endfunction

   function automatic logic [63:0] model(input logic [63:0] a, input logic ld,
         input logic [1:0] m, input logic [15:0] imm, input logic rs,
         input logic [63:0] rd);
      if (rs) return rd;
      if (!ld) return a;
      case (m)
         2'd0:    return {a[47:0], imm};
         2'd1:    return {48'd0, imm};
         2'd2:    return {32'd0, a[15:0], imm};
         default: return 64'd0;
      endcase
   endfunction

   task automatic chk(input bit ok, input string tag, input logic [63:0] act,
         input logic [63:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   // one cycle of stimulus; outputs checked on the following falling edge
   task automatic cyc(input logic ld, input logic [1:0] m, input logic [15:0] imm,
         input logic cm, input logic [5:0] dst, input logic sv, input logic rs,
         input logic [63:0] rd, input string tag);
      logic [63:0] old_acc = exp_acc;
      logic [63:0] new_acc = model(exp_acc, ld, m, imm, rs, rd);
      ld_i = ld; ld_mode_i = m; ld_imm_i = imm; commit_i = cm;
      commit_dst_i = dst; save_i = sv; restore_i = rs; restore_data_i = rd;
      @(posedge clk);
      @(negedge clk);
      exp_acc = new_acc;
      chk(wr_en_o == cm, "R7 wr_en", {63'd0, wr_en_o}, {63'd0, cm});
      if (cm) begin
         chk(wr_idx_o == dst, "R7 wr_idx", {58'd0, wr_idx_o}, {58'd0, dst});
         chk(wr_data_o == new_acc, tag, wr_data_o, new_acc);
      end
      chk(save_vld_o == sv, "R9 save_vld", {63'd0, save_vld_o}, {63'd0, sv});
      if (sv) chk(save_data_o == old_acc, "R9 save_data", save_data_o, old_acc);
      ld_i = 1'b0; commit_i = 1'b0; save_i = 1'b0; restore_i = 1'b0;
   endtask

   initial begin
      rst_n = 1'b0; ld_i = 1'b0; ld_mode_i = 2'd0; ld_imm_i = 16'hFFFF;
      commit_i = 1'b0; commit_dst_i = 6'd0; save_i = 1'b0; restore_i = 1'b0;
      restore_data_i = '0; exp_acc = '0;
      repeat (3) @(posedge clk);
      @(negedge clk);
      chk(!wr_en_o && !save_vld_o, "R1 reset outputs", {62'd0, wr_en_o, save_vld_o}, 64'd0);
      rst_n = 1'b1;
      cyc(1'b0, 2'd0, 16'h0, 1'b1, 6'd3, 1'b0, 1'b0, 64'd0, "R1 acc zero after reset");

      // R3 exact four-step constant, last step merged with commit (R8)
      cyc(1'b1, 2'd3, 16'hAAAA, 1'b0, 6'd0, 1'b0, 1'b0, 64'd0, "R6");
      cyc(1'b1, 2'd0, 16'h1234, 1'b0, 6'd0, 1'b0, 1'b0, 64'd0, "R3");
      cyc(1'b1, 2'd0, 16'h5678, 1'b0, 6'd0, 1'b0, 1'b0, 64'd0, "R3");
      cyc(1'b1, 2'd0, 16'h9ABC, 1'b0, 6'd0, 1'b0, 1'b0, 64'd0, "R3");
      cyc(1'b1, 2'd0, 16'hDEF0, 1'b1, 6'd9, 1'b0, 1'b0, 64'd0, "R8 merged step");
      chk(wr_data_o == 64'h123456789ABCDEF0, "R3 exact constant", wr_data_o,
          64'h123456789ABCDEF0);
      // R9 save concurrent with a step sees the old value
      cyc(1'b1, 2'd0, 16'h4242, 1'b1, 6'd1, 1'b1, 1'b0, 64'd0, "R2 shift");
      // R10 restore beats a concurrent step
      cyc(1'b1, 2'd0, 16'h7777, 1'b1, 6'd2, 1'b0, 1'b1, 64'hCAFE_F00D_0BAD_BEEF, "R10 restore wins");
      // R11 imm wiggles without ld have no effect
      cyc(1'b0, 2'd1, 16'h5555, 1'b1, 6'd4, 1'b0, 1'b0, 64'd0, "R11 hold");
      cyc(1'b1, 2'd2, 16'h0101, 1'b1, 6'd5, 1'b0, 1'b0, 64'd0, "R5 zx32");
      cyc(1'b1, 2'd1, 16'hFEED, 1'b1, 6'd6, 1'b1, 1'b0, 64'd0, "R4 zx16");

      // near-exhaustive sweep over strobe combinations with pseudo-random data
      for (int i = 0; i < 4000; i++) begin
         logic [31:0] a, b;
         string t;
         seed = rnd(seed); a = seed;
         seed = rnd(seed); b = seed;
         if (a[4]) t = "R10";
         else if (!a[0]) t = "R11";
         else case (a[2:1])
            2'd0: t = "R2";
            2'd1: t = "R4";
            2'd2: t = "R5";
            default: t = "R6";
         endcase
         cyc(a[0], a[2:1], b[15:0], a[3] | a[5], a[11:6], a[12] & a[13],
             a[4] & a[14] & a[15], {b, a}, t);
      end

      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      errors++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule